// File: doc/BRIEF.md
# Floppy Track Playback Sequencer

This block stands in for the drive side of a floppy for a host disk controller. In read mode it plays one stored track over and over. Each revolution is an index pulse, a fixed quiet gap, and then the track bytes in address order, handed one at a time to an asynchronous serial transmitter through a valid/ready handshake. When the last byte of the programmed track length has been accepted, the next revolution begins at once with a fresh index pulse. Playback does not depend on any head-load state. It runs for as long as the run input is high.

In write mode the block emits the index pulse and then listens. Every byte presented on the receive side is stored at consecutive addresses starting from zero, and the address wraps when it passes the end of the track buffer. A change of the track-select value, or a switch between read and write, abandons the current revolution and starts a new one with an index pulse. The track length is taken in at the start of each index pulse. The index pulse width and the gap length are parameters in clock cycles, and each defaults to one millisecond of the configured clock.

Top module: `trk_player`

## Requirements
- R1: While `run` is low (including straight after reset), `index_o` and `tx_valid` are both low.
- R2: Every index pulse, whether it starts a revolution, follows a wrap, or opens a write, stays high for exactly INDEX_CYC cycles.
- R3: In read mode, `tx_valid` first rises exactly GAP_CYC cycles after `index_o` falls.
- R4: In read mode, the track bytes are presented from address 0 upward, one per accepted handshake (`tx_valid` and `tx_ready` both high at a clock edge). While `tx_ready` is low, `tx_data` is held.
- R5: In the cycle after the handshake that accepts byte number `trk_len`-1, `index_o` is high and the sequence begins again.
- R6: With `trk_len` = 0, the block cycles through index and gap only and never raises `tx_valid`.
- R7: A `trk_len` larger than the buffer depth (2^ADDR_W bytes) replays the buffer from address 0 after its last entry, so byte n is the entry at address n mod 2^ADDR_W.
- R8: Raising `wr_en` starts an index pulse. After the pulse, each cycle with `rx_valid` high stores `rx_data` at the next address from 0. `tx_valid` stays low throughout write mode.
- R9: A capture longer than the buffer depth wraps to address 0 and overwrites earlier bytes.
- R10: A change of `trk_sel` while running puts `index_o` high and `tx_valid` low in the next cycle. The following playback restarts from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the sequencer; low holds it idle |
| wr_en | input | 1 | High selects capture mode, low selects playback |
| trk_sel | input | TRK_W | Selected track number; any change restarts the sequence |
| trk_len | input | ADDR_W+1 | Track length in bytes, taken in at each index pulse start |
| index_o | output | 1 | Index pulse |
| tx_data | output | 8 | Byte offered to the serial transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_data | input | 8 | Incoming byte from the host during capture |
| rx_valid | input | 1 | `rx_data` is valid this cycle |

## Verification
On every cycle the embedded properties check these rules: the idle behaviour while disabled, the one-cycle restart on a track change, the exact index and gap timer lengths at each phase exit, the absence of transmit activity while write is enabled, and the holding of a byte that the transmitter has not taken. The content-level behaviour needs the bench's scenarios. This covers the byte order across a whole revolution, the wrap back to index after the last byte, the zero-length track, replay wrap when the length exceeds the buffer, and capture wrap that overwrites earlier data. Each of these depends on what was written earlier, which only an end-to-end write-then-read scenario can compare.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INDEX = 3'd1,
        ST_GAP   = 3'd2,
        ST_DATA  = 3'd3,
        ST_CAPT  = 3'd4
    } trk_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    function automatic int unsigned cyc_per_ms(input int unsigned clk_hz);
        return clk_hz / 1000;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trk_addr.sv
module trk_addr #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/trk_mem.sv
module trk_mem #(
    parameter int unsigned ADDR_W = 9
) (
    input  logic                clk,
    input  trk_pkg::byte_beat_t wr_beat,
    input  logic [ADDR_W-1:0]   addr,
    output logic [7:0]          rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_beat.valid) begin
            store[addr] <= wr_beat.data;
        end
    end

    assign rdata = store[addr];
endmodule

// File: rtl/trk_seq.sv
module trk_seq
    import trk_pkg::*;
#(
    parameter int unsigned INDEX_CYC = 1000,
    parameter int unsigned GAP_CYC   = 1000,
    parameter int unsigned TRK_W     = 7,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_en,
    input  logic [TRK_W-1:0] trk_sel,
    input  logic [CNT_W-1:0] trk_len,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [CNT_W-1:0] cnt,
    output trk_state_e       state,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             restart
);
    localparam int unsigned TMR_MAX = max2(INDEX_CYC, GAP_CYC);
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    trk_state_e       nxt;
    logic [TMR_W-1:0] tmr;
    logic             tmr_clr;
    logic [TRK_W-1:0] trk_q;
    logic             wr_q;
    logic [CNT_W-1:0] len_q;
    logic             len_ld;
    logic             idx_end, gap_end, last_byte;

    assign restart   = run && (state == ST_IDLE || trk_sel != trk_q || wr_en != wr_q);
    assign idx_end   = (tmr == TMR_W'(INDEX_CYC - 1));
    assign gap_end   = (tmr == TMR_W'(GAP_CYC - 1));
    assign last_byte = (cnt == len_q - CNT_W'(1));

    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        len_ld  = 1'b0;
        if (!run) begin
            nxt = ST_IDLE;
        end else if (restart) begin
            nxt     = ST_INDEX;
            tmr_clr = 1'b1;
            cnt_clr = 1'b1;
            len_ld  = 1'b1;
        end else begin
            unique case (state)
                ST_INDEX: begin
                    if (idx_end) begin
                        nxt     = wr_q ? ST_CAPT : ST_GAP;
                        tmr_clr = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap_end) begin
                        tmr_clr = 1'b1;
                        if (len_q == '0) begin
                            nxt     = ST_INDEX;
                            cnt_clr = 1'b1;
                            len_ld  = 1'b1;
                        end else begin
                            nxt = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (tx_ready) begin
                        if (last_byte) begin
                            nxt     = ST_INDEX;
                            tmr_clr = 1'b1;
                            cnt_clr = 1'b1;
                            len_ld  = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_CAPT: begin
                    cnt_inc = rx_valid;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tmr   <= '0;
            trk_q <= '0;
            wr_q  <= 1'b0;
            len_q <= '0;
        end else begin
            state <= nxt;
            trk_q <= trk_sel;
            wr_q  <= wr_en;
            if (len_ld) begin
                len_q <= trk_len;
            end
            if (tmr_clr) begin
                tmr <= '0;
            end else if (state == ST_INDEX || state == ST_GAP) begin
                tmr <= tmr + TMR_W'(1);
            end
        end
    end

    AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> state == ST_IDLE); // R1

    AST_INDEX_FULL_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (state != ST_INDEX && $past(state) == ST_INDEX && $past(run))
        |-> $past(tmr) == TMR_W'(INDEX_CYC - 1)); // R2

    AST_GAP_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_GAP)
        |-> $past(tmr) == TMR_W'(GAP_CYC - 1)); // R3

    AST_TRACK_CHANGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run && trk_sel != trk_q) |=> state == ST_INDEX); // R10

endmodule

// File: rtl/trk_player.sv
module trk_player
    import trk_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 1_000_000,
    parameter int unsigned INDEX_CYC = cyc_per_ms(CLK_HZ),
    parameter int unsigned GAP_CYC   = cyc_per_ms(CLK_HZ),
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned TRK_W     = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                wr_en,
    input  logic [TRK_W-1:0]    trk_sel,
    input  logic [ADDR_W:0]     trk_len,
    output logic                index_o,
    output logic [7:0]          tx_data,
    output logic                tx_valid,
    input  logic                tx_ready,
    input  logic [7:0]          rx_data,
    input  logic                rx_valid
);
    localparam int unsigned CNT_W = ADDR_W + 1;

    trk_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_inc, restart;
    byte_beat_t       wr_beat;

    trk_seq #(
        .INDEX_CYC (INDEX_CYC),
        .GAP_CYC   (GAP_CYC),
        .TRK_W     (TRK_W),
        .CNT_W     (CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wr_en    (wr_en),
        .trk_sel  (trk_sel),
        .trk_len  (trk_len),
        .tx_ready (tx_ready),
        .rx_valid (rx_valid),
        .cnt      (cnt),
        .state    (state),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .restart  (restart)
    );

    trk_addr #(.CNT_W(CNT_W)) addr_i (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .cnt (cnt)
    );

    always_comb begin
        wr_beat.valid = (state == ST_CAPT) && rx_valid && run && !restart;
        wr_beat.data  = rx_data;
    end

    trk_mem #(.ADDR_W(ADDR_W)) mem_i (
        .clk     (clk),
        .wr_beat (wr_beat),
        .addr    (cnt[ADDR_W-1:0]),
        .rdata   (tx_data)
    );

    assign index_o  = (state == ST_INDEX);
    assign tx_valid = (state == ST_DATA);

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && run && !restart)
        |=> tx_valid && $stable(tx_data)); // R4

    AST_SILENT_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_valid); // R8

    AST_STOPPED_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !run |=> !index_o && !tx_valid); // R1

endmodule

// File: tb/trk_player_tb.sv
module trk_player_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX   = 5;
    localparam int GAP   = 7;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int TW    = 3;
    localparam int NVEC  = 6;

    localparam logic [7:0] VEC_LEN  [NVEC] = '{8'd16, 8'd5, 8'd20, 8'd16, 8'd0, 8'd1};
    localparam logic [7:0] VEC_NW   [NVEC] = '{8'd16, 8'd5, 8'd16, 8'd20, 8'd3, 8'd1};
    localparam logic [7:0] VEC_SEED [NVEC] = '{8'h11, 8'h3C, 8'hA5, 8'h5A, 8'h77, 8'hC3};
    localparam logic [7:0] VEC_RDY  [NVEC] = '{8'hFF, 8'hB6, 8'hFF, 8'hDD, 8'hFF, 8'h55};

    logic          clk = 1'b0;
    logic          rst, run, wr_en, tx_ready, rx_valid, tx_valid, index_o;
    logic [TW-1:0] trk_sel;
    logic [AW:0]   trk_len;
    logic [7:0]    tx_data, rx_data;

    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc   = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] rdy_pat;

    trk_player #(
        .INDEX_CYC (IDX),
        .GAP_CYC   (GAP),
        .ADDR_W    (AW),
        .TRK_W     (TW)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wr_en    (wr_en),
        .trk_sel  (trk_sel),
        .trk_len  (trk_len),
        .index_o  (index_o),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_track(input int n, input logic [7:0] seed);
        int w = 0;
        int txv = 0;
        wr_en = 1'b1;
        tick();
        while (index_o && w < 1000) begin
            w++;
            tick();
        end
        chk("R8 write index width", w, IDX);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = seed + 8'(i * 29);
            model[i % DEPTH] = rx_data;
            if (tx_valid) txv++;
            tick();
        end
        rx_valid = 1'b0;
        chk("R8 no transmit while writing", txv, 0);
    endtask

    task automatic read_rev(input int len, input string tag);
        int w = 0;
        int g = 0;
        int k = 0;
        int guard = 0;
        logic       held = 1'b0;
        logic [7:0] hv = '0;
        while (!index_o && guard < 1000) begin
            guard++;
            tick();
        end
        while (index_o && w < 1000) begin
            w++;
            tick();
        end
        chk("R2 index width", w, IDX);
        while (!tx_valid && !index_o && g < 1000) begin
            g++;
            tick();
        end
        chk("R3 gap length", g, GAP);
        if (len == 0) begin
            chk("R6 empty track returns to index", int'(index_o), 1);
            chk("R6 empty track sends nothing", int'(tx_valid), 0);
            return;
        end
        guard = 0;
        while (k < len && guard < 5000) begin
            guard++;
            tx_ready = rdy_pat[cyc % 8];
            if (held) chk("R4 byte held while not ready", int'(tx_data), int'(hv));
            if (tx_valid && tx_ready) begin
                chk(tag, int'(tx_data), int'(model[k % DEPTH]));
                k++;
            end
            held = tx_valid && !tx_ready;
            hv   = tx_data;
            tick();
        end
        tx_ready = 1'b0;
        chk("R5 index after last byte", int'(index_o), 1);
    endtask

    initial begin
        rst = 1'b1; run = 1'b0; wr_en = 1'b0; trk_sel = '0; trk_len = '0;
        tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; rdy_pat = 8'hFF;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset and idle state
        chk("R1 index low after reset", int'(index_o), 0);
        chk("R1 tx_valid low after reset", int'(tx_valid), 0);
        repeat (5) tick();
        chk("R1 still idle with run low", int'(index_o | tx_valid), 0);

        run = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = (v == 2) ? "R7 replay wrap byte" : (v == 3) ? "R9 capture wrap byte" : "R4 byte order";
            trk_len = VEC_LEN[v][AW:0];
            rdy_pat = VEC_RDY[v];
            write_track(int'(VEC_NW[v]), VEC_SEED[v]);
            wr_en = 1'b0;
            read_rev(int'(VEC_LEN[v]), tag);
            read_rev(int'(VEC_LEN[v]), tag);
        end

        // R10: track change in the middle of the data phase
        trk_len = 5'd16;
        rdy_pat = 8'hFF;
        write_track(16, 8'h42);
        wr_en = 1'b0;
        tick();
        for (int i = 0; i < 200 && !tx_valid; i++) tick();
        tx_ready = 1'b1;
        repeat (3) tick();
        tx_ready = 1'b0;
        trk_sel = trk_sel + 1'b1;
        tick();
        chk("R10 index after track change", int'(index_o), 1);
        chk("R10 no data after track change", int'(tx_valid), 0);
        read_rev(16, "R10 playback from byte 0");

        // R1: dropping run mid-sequence
        run = 1'b0;
        tick();
        chk("R1 idle after run drops", int'(index_o | tx_valid), 0);
        repeat (4) tick();
        run = 1'b1;
        read_rev(16, "R4 byte order after rerun");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule